// File: doc/BRIEF.md
# Lowest-Bit Manipulation ALU

This block transforms an operand around its lowest set bit or its lowest clear bit. It isolates, masks, fills, sets, clears or complements that bit. The results come from three shared carry chains: x+1, x-1 and the two's complement of x. Each chain's output is combined with x or with ~x through one gate level. The same unit also performs an AND with a complemented operand, a bit-field extract, and a clear-above-index operation. Those three share one shifter and mask path.

A caller drives two operands, a 4-bit operation code and a valid strobe. One clock later the registered result appears with a zero flag, a carry flag and an output valid. The operand width `W` (32 or 64 in normal use) and the width `POS_W` of the position fields carried in the second operand are parameters. `W` must be at least `2*POS_W`.

Top module: `lbm_alu`

## Requirements
- R1: Code 0 (and-with-complement) returns `~a & b`.
- R2: Codes 1, 2 and 3 work on the lowest set bit of `a`. Code 1 returns `a & -a`, code 2 returns `a ^ (a-1)`, and code 3 returns `a & (a-1)`.
- R3: Codes 4, 5, 6 and 7 work on the lowest clear bit of `a`. Code 4 returns `a & (a+1)`, code 5 returns `a | (a+1)`, code 6 returns `a ^ (a+1)`, and code 7 returns `~a & (a+1)`.
- R4: Code 8 returns `~a & (a-1)`, the mask of the trailing zeros. Code 9 returns `~a | (a+1)`, the inverted mask of the trailing ones.
- R5: Code 12 returns `a | ~(a+1)`, code 13 returns `a | (a-1)`, and code 14 returns `~a | (a-1)`.
- R6: Code 10 (field extract) takes its start position from `b[POS_W-1:0]` and its length from `b[2*POS_W-1:POS_W]`. It returns `a` shifted right by the start position, with only the lowest length bits kept.
- R7: In a field extract, a start of `W` or more gives zero, and a length of `W` or more keeps every bit that remains after the shift.
- R8: Code 11 (clear-above-index) takes its index from `b[POS_W-1:0]`. It keeps the bits of `a` below the index and clears every bit at or above it. An index of `W` or more passes `a` unchanged.
- R9: Code 15 is reserved. It returns zero with the zero flag set and the carry flag clear.
- R10: The zero flag is set exactly when the result is zero.
- R11: The carry flag is set exactly when the code is one of 1–9 or 12–14 and `a` is zero. For codes 0, 10, 11 and 15 the carry flag is always clear.
- R12: Result and flags appear one clock after an accepted input. `out_valid` is set in the cycle after `in_valid` is high and clear in the cycle after it is low. The result and flags are held while `in_valid` is low.
- R13: While `rst` is high, `out_valid`, `out_result`, `out_zf` and `out_cf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and code are valid this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | W | Primary operand |
| in_b | input | W | Second operand, or the position fields |
| out_valid | output | 1 | Result registered from an accepted input |
| out_result | output | W | Registered result |
| out_zf | output | 1 | Result is zero |
| out_cf | output | 1 | Lowest-bit operation on a zero operand |

## Verification
Three situations are hard to reach from the ports. The first is a carry chain that wraps around: an all-zero operand for the decrement chain, or an all-ones operand for the increment chain. The second is an extract whose start or length lies beyond the operand width. The third is a start plus length that runs past the top bit. The bench uses an 8-bit instance with 4-bit position fields, so the position fields reach values from 8 to 15 and cover every one of these cases. It sweeps all 256 operands for each lowest-bit code, so both wrap-around operands come up naturally. It sweeps every start and length pair for the extract and every index for the clear-above-index operation.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  typedef enum logic [3:0] {
    OP_ANDNOT     = 4'd0,
    OP_LS_ISOLATE = 4'd1,
    OP_LS_MASK    = 4'd2,
    OP_LS_CLEAR   = 4'd3,
    OP_LC_FILL    = 4'd4,
    OP_LC_SET     = 4'd5,
    OP_LC_MASK    = 4'd6,
    OP_LC_ONEHOT  = 4'd7,
    OP_TZ_MASK    = 4'd8,
    OP_TO_INVMASK = 4'd9,
    OP_FIELD_GET  = 4'd10,
    OP_HIGH_CLEAR = 4'd11,
    OP_LC_HOLE    = 4'd12,
    OP_LS_FILL    = 4'd13,
    OP_LS_HOLE    = 4'd14,
    OP_NONE       = 4'd15
  } op_e;

  // True for codes whose result is built from the carry chains on operand a.
  function automatic logic is_lowbit(op_e op);
    case (op)
      OP_ANDNOT, OP_FIELD_GET, OP_HIGH_CLEAR, OP_NONE: return 1'b0;
      default:                                         return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/lbm_lowbit.sv
module lbm_lowbit #(
  parameter int W = 32
) (
  input  logic [W-1:0]  x,
  input  lbm_pkg::op_e  op,
  output logic [W-1:0]  result
);
  import lbm_pkg::*;

  logic [W-1:0] x_inc;
  logic [W-1:0] x_dec;
  logic [W-1:0] x_neg;
  logic [W-1:0] x_inv;

  // Three carry chains shared by every lowest-bit code.
  assign x_inc = x + W'(1);
  assign x_dec = x - W'(1);
  assign x_inv = ~x;
  assign x_neg = x_inv + W'(1);

  always_comb begin
    case (op)
      OP_LS_ISOLATE: result = x & x_neg;
      OP_LS_MASK:    result = x ^ x_dec;
      OP_LS_CLEAR:   result = x & x_dec;
      OP_LC_FILL:    result = x & x_inc;
      OP_LC_SET:     result = x | x_inc;
      OP_LC_MASK:    result = x ^ x_inc;
      OP_LC_ONEHOT:  result = x_inv & x_inc;
      OP_TZ_MASK:    result = x_inv & x_dec;
      OP_TO_INVMASK: result = x_inv | x_inc;
      OP_LC_HOLE:    result = x | ~x_inc;
      OP_LS_FILL:    result = x | x_dec;
      OP_LS_HOLE:    result = x_inv | x_dec;
      default:       result = '0;
    endcase
  end

  // R2: the decrement and negate chains differ in exactly their bit-0 relation:
  // -x equals ~(x-1) for every x, so the two adders must agree.
  always_comb begin
    if (!$isunknown(x))
      a_r2_chain_agree: assert (x_neg == ~x_dec);
  end

endmodule

// File: rtl/lbm_field.sv
module lbm_field #(
  parameter int W     = 32,
  parameter int POS_W = 8
) (
  input  logic [W-1:0]     src,
  input  logic [POS_W-1:0] start,
  input  logic [POS_W-1:0] len,
  input  logic             high_clear,
  output logic [W-1:0]     result
);

  logic [POS_W-1:0] width_sel;
  logic [W-1:0]     shifted;
  logic [W-1:0]     keep_mask;

  // Clear-above-index reuses the extract path with a start of zero and the
  // index taken from the start field.
  assign width_sel = high_clear ? start : len;

  always_comb begin
    if (high_clear)
      shifted = src;
    else if (int'(start) >= W)
      shifted = '0;
    else
      shifted = src >> start;
  end

  always_comb begin
    if (int'(width_sel) >= W)
      keep_mask = '1;
    else
      keep_mask = (W'(1) << width_sel) - W'(1);
  end

  assign result = shifted & keep_mask;

endmodule

// File: rtl/lbm_alu.sv
module lbm_alu #(
  parameter int W     = 32,
  parameter int POS_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_zf,
  output logic         out_cf
);
  import lbm_pkg::*;

  localparam int FIELD_TOP = 2 * POS_W;

  op_e          op;
  logic [W-1:0] low_res;
  logic [W-1:0] field_res;
  logic [W-1:0] next_res;
  logic         next_cf;
  op_e          op_q;

  assign op = op_e'(in_op);

  lbm_lowbit #(.W(W)) u_lowbit (
    .x      (in_a),
    .op     (op),
    .result (low_res)
  );

  lbm_field #(.W(W), .POS_W(POS_W)) u_field (
    .src        (in_a),
    .start      (in_b[POS_W-1:0]),
    .len        (in_b[FIELD_TOP-1:POS_W]),
    .high_clear (op == OP_HIGH_CLEAR),
    .result     (field_res)
  );

  always_comb begin
    case (op)
      OP_ANDNOT:                   next_res = ~in_a & in_b;
      OP_FIELD_GET, OP_HIGH_CLEAR: next_res = field_res;
      OP_NONE:                     next_res = '0;
      default:                     next_res = low_res;
    endcase
  end

  assign next_cf = is_lowbit(op) && (in_a == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zf     <= 1'b0;
      out_cf     <= 1'b0;
      op_q       <= OP_NONE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= next_res;
        out_zf     <= (next_res == '0);
        out_cf     <= next_cf;
        op_q       <= op;
      end
    end
  end

  // R12: output valid trails the input strobe by one cycle.
  a_r12_valid_lag: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r12_idle_lag: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R12: result held when no input is accepted.
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));
  // R10: zero flag tracks the registered result.
  a_r10_zero_flag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_zf == (out_result == '0)));
  // R11: carry only ever reported for a lowest-bit code.
  a_r11_carry_group: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cf) |-> is_lowbit(op_q));
  // R2: isolating the lowest set bit leaves at most one bit.
  a_r2_isolate_onehot: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q == OP_LS_ISOLATE) |-> $onehot0(out_result));
  // R3: isolating the lowest clear bit leaves at most one bit.
  a_r3_clear_onehot: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q == OP_LC_ONEHOT) |-> $onehot0(out_result));
  // R9: reserved code gives zero with only the zero flag.
  a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q == OP_NONE) |-> (out_zf && !out_cf));

endmodule

// File: tb/tb_lbm_alu.sv
module tb_lbm_alu;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int POS_W      = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   in_op = '0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic [W-1:0] out_result;
  logic         out_zf;
  logic         out_cf;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbm_alu #(.W(W), .POS_W(POS_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_result(out_result), .out_zf(out_zf), .out_cf(out_cf)
  );

  function automatic string req_of(int op);
    case (op)
      0:           return "R1";
      1, 2, 3:     return "R2";
      4, 5, 6, 7:  return "R3";
      8, 9:        return "R4";
      10:          return "R6/R7";
      11:          return "R8";
      15:          return "R9";
      default:     return "R5";
    endcase
  endfunction

  // Bit-scan model built from the requirements, not from carry arithmetic.
  function automatic logic [W-1:0] model(int op, logic [W-1:0] a, logic [W-1:0] b);
    int ls = W;
    int lc = W;
    int st = int'(b[POS_W-1:0]);
    int ln = int'(b[2*POS_W-1:POS_W]);
    logic [W-1:0] r = '0;
    for (int i = W-1; i >= 0; i--) begin
      if (a[i]) ls = i; else lc = i;
    end
    case (op)
      0:  r = ~a & b;
      1:  if (ls < W) r[ls] = 1'b1;
      2:  for (int i = 0; i < W; i++) if (i <= ls) r[i] = 1'b1;
      3:  begin r = a; if (ls < W) r[ls] = 1'b0; end
      4:  begin r = a; for (int i = 0; i < W; i++) if (i < lc) r[i] = 1'b0; end
      5:  begin r = a; if (lc < W) r[lc] = 1'b1; end
      6:  for (int i = 0; i < W; i++) if (i <= lc) r[i] = 1'b1;
      7:  if (lc < W) r[lc] = 1'b1;
      8:  for (int i = 0; i < W; i++) if (i < ls) r[i] = 1'b1;
      9:  begin r = '1; for (int i = 0; i < W; i++) if (i < lc) r[i] = 1'b0; end
      10: for (int i = 0; i < W; i++) if (i < ln && st + i < W) r[i] = a[st+i];
      11: for (int i = 0; i < W; i++) if (i < st) r[i] = a[i];
      12: begin r = '1; if (lc < W) r[lc] = 1'b0; end
      13: begin r = a; for (int i = 0; i < W; i++) if (i < ls) r[i] = 1'b1; end
      14: begin r = '1; if (ls < W) r[ls] = 1'b0; end
      default: r = '0;
    endcase
    return r;
  endfunction

  // Called at a falling edge; drives one vector and checks it one cycle later.
  task automatic run_vec(int op, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] er;
    logic ez;
    logic ec;
    in_op    = op[3:0];
    in_a     = a;
    in_b     = b;
    in_valid = 1'b1;
    er = model(op, a, b);
    ez = (er == '0);                                        // R10
    ec = (op inside {[1:9], [12:14]}) && (a == '0);         // R11
    @(negedge clk);
    n_tests++;
    if (!out_valid || out_result !== er || out_zf !== ez || out_cf !== ec) begin
      n_fail++;
      $display("FAIL %s/R10/R11/R12 op=%0d a=%h b=%h: got v=%b r=%h zf=%b cf=%b, expected v=1 r=%h zf=%b cf=%b",
               req_of(op), op, a, b, out_valid, out_result, out_zf, out_cf, er, ez, ec);
    end
  endtask

  task automatic check_bit(string req, logic got, logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    // R13: reset state
    check_bit("R13 out_valid", out_valid, 1'b0);
    check_bit("R13 out_result zero", out_result == '0, 1'b1);
    check_bit("R13 out_zf", out_zf, 1'b0);
    check_bit("R13 out_cf", out_cf, 1'b0);
    rst = 1'b0;

    // R2 R3 R4 R5 R9 R11: every lowest-bit code and the reserved code over all operands
    for (int op = 1; op < 16; op++) begin
      if (op == 10 || op == 11) continue;
      for (int a = 0; a < (1 << W); a++) run_vec(op, W'(a), W'(a * 37 + 5));
    end
    // R1: all first operands against a spread of second operands
    for (int b = 0; b < 16; b++)
      for (int a = 0; a < (1 << W); a++) run_vec(0, W'(a), W'(b * 17 + 3));
    // R6 R7: every start/length pair, including positions at or past W
    for (int k = 0; k < 16; k++)
      for (int b = 0; b < (1 << W); b++) run_vec(10, W'(k * 73 + 11), W'(b));
    // R8: every index, including indices at or past W
    for (int a = 0; a < (1 << W); a += 7)
      for (int idx = 0; idx < (1 << POS_W); idx++) run_vec(11, W'(a), W'(idx | 8'h50));

    // R12: idle cycle keeps the result and drops out_valid
    held = out_result;
    in_valid = 1'b0;
    in_op    = 4'd1;
    in_a     = ~in_a;
    @(negedge clk);
    check_bit("R12 out_valid low after idle", out_valid, 1'b0);
    check_bit("R12 result held", out_result == held, 1'b1);
    // R12: valid returns with the next accepted input
    run_vec(1, 8'h68, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule